// File: doc/BRIEF.md
# Audio link frame serializer

This block is the transmit side of a fixed-rate serial audio link, on the controller end. It runs on a bit clock that comes from outside the block. It sends back-to-back frames of 256 bits each. A frame opens with a 16-bit tag slot and continues with twelve 20-bit data slots. With a 12.288 MHz bit clock the frame rate is 48 kHz. The block drives three outputs: a frame sync strobe, a serial data line and a one-cycle frame-start marker. All of them change only on rising edges of the bit clock.

Upstream logic supplies one frame descriptor at a time over a valid/ready handshake. A descriptor holds twelve slot-valid flags, the twelve slot payloads and a 2-bit codec ID. The block keeps one descriptor. `in_ready` is high while that store is empty, and a transfer happens on any rising edge where `in_valid` and `in_ready` are both high. The store is emptied at the start of each frame. While `in_valid` is high and `in_ready` is low, the source must hold the descriptor unchanged. The stored descriptor is copied into the output shift path as a frame begins, so the contents of a frame cannot change while it is being sent.

The tag word is computed from the flags. Slots whose flag is clear are sent as zeros. When `en` is low, the block finishes the frame it is sending and then goes quiet. Its state, including any stored descriptor, is kept until `en` is raised again.

Top module: `audio_frame_tx`

## Requirements
- R1: A frame is 256 bit times long. It carries the 16-bit tag first, then slot 1 through slot 12 with 20 bits each. Every field is sent most significant bit first. The first tag bit appears in the cycle where `frame_start` is high. Slot k (k = 1..12) is taken from `in_slot_data[(k-1)*20 +: 20]`.
- R2: `frame_sync` is high for exactly the 16 tag bit times of each frame and low for the other 240.
- R3: Tag bit 15 (the first bit sent) is 1 exactly when at least one of the 12 slot flags in the sent descriptor is 1.
- R4: Tag bits 14 down to 3 carry the flags of slots 1 to 12 in that order. Slot k's flag is `in_slot_valid[k-1]`, so tag bit 14 is slot 1 and tag bit 3 is slot 12.
- R5: Tag bit 2 is always 0. Tag bits 1:0 are `in_codec_id` of the sent descriptor, where 00 means the primary codec and 01 a secondary one.
- R6: Every bit of a slot whose flag is 0 is sent as 0, whatever its payload.
- R7: `in_ready` is high exactly while no descriptor is stored. A descriptor accepted while a frame is running is sent in the next frame. A source held back by a low `in_ready` is accepted once the running frame ends, and its descriptor is sent in the frame after that.
- R8: A frame that begins with no descriptor stored is sent as 256 zero bits. `frame_sync` and `frame_start` still follow R1 and R2.
- R9: After `en` goes low, the running frame completes. From then on `frame_sync`, `ser_data` and `frame_start` stay low. Once `en` is seen high again on a rising edge, a new frame begins on that edge, and it carries any descriptor stored during the pause.
- R10: While `en` stays high, frames follow each other with no gap. `frame_start` is high for one cycle out of every 256.
- R11: After reset, `frame_sync`, `ser_data` and `frame_start` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from outside; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; when low, the link halts at the next frame boundary |
| in_valid | input | 1 | A frame descriptor is offered |
| in_ready | output | 1 | The descriptor store is empty |
| in_slot_valid | input | 12 | Bit k-1 is the valid flag of slot k |
| in_slot_data | input | 240 | Payloads; slot k occupies bits (k-1)*20 +: 20 |
| in_codec_id | input | 2 | Codec ID placed in tag bits 1:0 |
| frame_sync | output | 1 | High during the tag phase of each frame |
| ser_data | output | 1 | Serial frame data, MSB first |
| frame_start | output | 1 | High in the first bit time of each frame |

## Verification
Some properties are checked on every cycle. Sync must be high whenever a frame starts, and it must drop right after the sixteenth tag bit. The reserved tag bit must be zero. The outputs must stay quiet while the link is halted. An accepted descriptor must close the store. When the link runs past the last bit of a frame, the next frame must start at once. The bench's frame-by-frame scenarios are the only way to show the rest: that each tag field and slot lands in the right bit position, that invalid slots are zero-stuffed, that a descriptor reaches the right frame under back-pressure, and that the frame sent after a pause carries the descriptor stored during it.

// File: rtl/afs_pkg.sv
package afs_pkg;
  // Tag slot width and codec ID width are fixed by the link protocol.
  localparam int TAG_W = 16;
  localparam int CID_W = 2;
endpackage

// File: rtl/afs_desc_buffer.sv
// One-entry store for a frame descriptor, filled over valid/ready
// and emptied when the sequencer opens a frame.
module afs_desc_buffer #(
  parameter int NUM_SLOTS = 12,
  parameter int SLOT_W    = 20,
  parameter int CID_W     = afs_pkg::CID_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [NUM_SLOTS-1:0]        in_flags,
  input  logic [NUM_SLOTS*SLOT_W-1:0] in_data,
  input  logic [CID_W-1:0]            in_cid,
  input  logic                        take,
  output logic                        held,
  output logic [NUM_SLOTS-1:0]        flags,
  output logic [NUM_SLOTS*SLOT_W-1:0] data,
  output logic [CID_W-1:0]            cid
);
  logic accept;

  assign in_ready = !held;
  assign accept   = in_valid && !held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= 1'b0;
      flags <= '0;
      data  <= '0;
      cid   <= '0;
    end else begin
      if (accept) begin
        held  <= 1'b1;
        flags <= in_flags;
        data  <= in_data;
        cid   <= in_cid;
      end else if (take) begin
        held <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/afs_frame_builder.sv
// Combinational assembly of the full frame word: tag, then zero-stuffed slots.
module afs_frame_builder #(
  parameter int NUM_SLOTS = 12,
  parameter int SLOT_W    = 20,
  parameter int TAG_W     = afs_pkg::TAG_W,
  parameter int CID_W     = afs_pkg::CID_W,
  parameter int FRAME_W   = TAG_W + NUM_SLOTS * SLOT_W
) (
  input  logic                        have,
  input  logic [NUM_SLOTS-1:0]        flags,
  input  logic [NUM_SLOTS*SLOT_W-1:0] data,
  input  logic [CID_W-1:0]            cid,
  output logic [FRAME_W-1:0]          frame_word
);
  localparam int BODY_W  = NUM_SLOTS * SLOT_W;
  localparam int RSV_TOP = TAG_W - 2 - NUM_SLOTS;

  logic [TAG_W-1:0]  tag;
  logic [BODY_W-1:0] body;

  // frame-valid flag leads the tag
  assign tag[TAG_W-1] = |flags;

  // per-slot flags and payloads; slot 1 goes first
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    assign tag[TAG_W-2-k] = flags[k];
    assign body[(NUM_SLOTS-1-k)*SLOT_W +: SLOT_W] =
      flags[k] ? data[k*SLOT_W +: SLOT_W] : '0;
  end

  // reserved positions between the flags and the codec ID
  for (genvar r = CID_W; r <= RSV_TOP; r++) begin : g_rsv
    assign tag[r] = 1'b0;
  end

  assign tag[CID_W-1:0] = cid;

  assign frame_word = have ? {tag, body} : '0;
endmodule

// File: rtl/afs_sequencer.sv
// Bit counter, frame shift register and the serial outputs.
module afs_sequencer #(
  parameter int TAG_W   = afs_pkg::TAG_W,
  parameter int FRAME_W = 256,
  parameter int CNT_W   = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [FRAME_W-1:0] frame_word,
  output logic               load,
  output logic               active,
  output logic [CNT_W-1:0]   bit_cnt,
  output logic               frame_sync,
  output logic               ser_data,
  output logic               frame_start
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] TAG_END  = CNT_W'(TAG_W);

  logic [FRAME_W-1:0] shreg;
  logic               at_last;
  logic               halt;

  assign at_last = active && (bit_cnt == LAST_POS);
  assign load    = en && (!active || at_last);
  assign halt    = at_last && !en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (load) begin
      active  <= 1'b1;
      bit_cnt <= '0;
      shreg   <= frame_word;
    end else if (halt) begin
      active  <= 1'b0;
      bit_cnt <= '0;
    end else if (active) begin
      bit_cnt <= bit_cnt + CNT_W'(1);
      shreg   <= {shreg[FRAME_W-2:0], 1'b0};
    end
  end

  assign frame_sync  = active && (bit_cnt < TAG_END);
  assign ser_data    = active && shreg[FRAME_W-1];
  assign frame_start = active && (bit_cnt == '0);
endmodule

// File: rtl/audio_frame_tx.sv
module audio_frame_tx #(
  parameter int NUM_SLOTS = 12,
  parameter int SLOT_W    = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [NUM_SLOTS-1:0]        in_slot_valid,
  input  logic [NUM_SLOTS*SLOT_W-1:0] in_slot_data,
  input  logic [afs_pkg::CID_W-1:0]   in_codec_id,
  output logic                        frame_sync,
  output logic                        ser_data,
  output logic                        frame_start
);
  localparam int TAG_W   = afs_pkg::TAG_W;
  localparam int CID_W   = afs_pkg::CID_W;
  localparam int FRAME_W = TAG_W + NUM_SLOTS * SLOT_W;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic                        load;
  logic                        held;
  logic [NUM_SLOTS-1:0]        st_flags;
  logic [NUM_SLOTS*SLOT_W-1:0] st_data;
  logic [CID_W-1:0]            st_cid;
  logic [FRAME_W-1:0]          frame_word;
  logic                        active;
  logic [CNT_W-1:0]            bit_cnt;

  afs_desc_buffer #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .CID_W(CID_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_flags (in_slot_valid),
    .in_data  (in_slot_data),
    .in_cid   (in_codec_id),
    .take     (load),
    .held     (held),
    .flags    (st_flags),
    .data     (st_data),
    .cid      (st_cid)
  );

  afs_frame_builder #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .TAG_W(TAG_W),
    .CID_W(CID_W), .FRAME_W(FRAME_W)
  ) u_build (
    .have       (held),
    .flags      (st_flags),
    .data       (st_data),
    .cid        (st_cid),
    .frame_word (frame_word)
  );

  afs_sequencer #(.TAG_W(TAG_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .frame_word  (frame_word),
    .load        (load),
    .active      (active),
    .bit_cnt     (bit_cnt),
    .frame_sync  (frame_sync),
    .ser_data    (ser_data),
    .frame_start (frame_start)
  );
endmodule

// File: rtl/afs_checker.sv
module afs_checker #(
  parameter int TAG_W   = 16,
  parameter int FRAME_W = 256,
  parameter int CNT_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             in_valid,
  input logic             in_ready,
  input logic             frame_sync,
  input logic             ser_data,
  input logic             frame_start,
  input logic             active,
  input logic [CNT_W-1:0] bit_cnt
);
  localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(TAG_W - 1);
  localparam logic [CNT_W-1:0] RSV_POS   = CNT_W'(TAG_W - 3);
  localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(FRAME_W - 1);

  p_start_in_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> frame_sync);

  p_sync_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_sync) |-> ($past(bit_cnt) == SYNC_LAST));

  p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bit_cnt == RSV_POS) |-> !ser_data);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!frame_sync && !ser_data && !frame_start));

  p_accept_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_no_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bit_cnt == LAST_POS && en) |=> frame_start);

  p_start_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
endmodule

bind audio_frame_tx afs_checker #(.TAG_W(TAG_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .frame_sync  (frame_sync),
  .ser_data    (ser_data),
  .frame_start (frame_start),
  .active      (active),
  .bit_cnt     (bit_cnt)
);

// File: tb/audio_frame_tx_test.sv
module audio_frame_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 12;
  localparam int SW = 20;
  localparam int FW = 16 + NS * SW;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              en;
  logic              in_valid;
  logic              in_ready;
  logic [NS-1:0]     in_slot_valid;
  logic [NS*SW-1:0]  in_slot_data;
  logic [1:0]        in_codec_id;
  logic              frame_sync;
  logic              ser_data;
  logic              frame_start;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_frame_tx uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_slot_valid (in_slot_valid),
    .in_slot_data  (in_slot_data),
    .in_codec_id   (in_codec_id),
    .frame_sync    (frame_sync),
    .ser_data      (ser_data),
    .frame_start   (frame_start)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] pat(input int v, input int k);
    return SW'((v * 7919 + k * 104729) ^ (k << 13) ^ 20'hA5C3B);
  endfunction

  function automatic logic [NS*SW-1:0] mk_data(input int v);
    logic [NS*SW-1:0] d;
    for (int k = 0; k < NS; k++) d[k*SW +: SW] = pat(v, k);
    return d;
  endfunction

  // Expected frame from the requirements: tag, then slots 1..12, zero-stuffed.
  function automatic logic [FW-1:0] exp_frame(input logic [NS-1:0] f,
                                              input logic [NS*SW-1:0] d,
                                              input logic [1:0] c);
    logic [FW-1:0] w;
    w = '0;
    w[FW-1] = |f;
    for (int k = 0; k < NS; k++) begin
      w[FW-2-k] = f[k];
      if (f[k]) w[FW-17-k*SW -: SW] = d[k*SW +: SW];
    end
    w[FW-14] = 1'b0;
    w[FW-15 -: 2] = c;
    return w;
  endfunction

  task automatic push(input logic [NS-1:0] f, input logic [NS*SW-1:0] d,
                      input logic [1:0] c);
    in_slot_valid = f;
    in_slot_data  = d;
    in_codec_id   = c;
    in_valid      = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7", "ready low after accept", 32'(in_ready), 32'd0);
  endtask

  task automatic wait_next_start();
    do @(negedge clk); while (!frame_start);
  endtask

  // Called at a negedge where the frame has just begun.
  task automatic capture(input logic [FW-1:0] exp, input int drop_at);
    logic [FW-1:0] got;
    int sync_err;
    int fs_err;
    sync_err = 0;
    fs_err   = 0;
    for (int i = 0; i < FW; i++) begin
      got[FW-1-i] = ser_data;
      if (frame_sync !== (i < 16)) sync_err++;
      if (frame_start !== (i == 0)) fs_err++;
      if (i == drop_at) en = 1'b0;
      @(negedge clk);
    end
    check("R3", "frame-valid tag bit", 32'(got[FW-1]), 32'(exp[FW-1]));
    check("R4", "slot flag tag bits", 32'(got[FW-2 -: NS]), 32'(exp[FW-2 -: NS]));
    check("R5", "reserved and codec ID", 32'(got[FW-14 -: 3]), 32'(exp[FW-14 -: 3]));
    for (int k = 0; k < NS; k++) begin
      if (exp[FW-2-k])
        check("R1", $sformatf("slot %0d payload", k + 1),
              32'(got[FW-17-k*SW -: SW]), 32'(exp[FW-17-k*SW -: SW]));
      else
        check("R6", $sformatf("slot %0d zero-stuffed", k + 1),
              32'(got[FW-17-k*SW -: SW]), 32'd0);
    end
    check("R2", "sync pattern errors", 32'(sync_err), 32'd0);
    check("R10", "single start pulse", 32'(fs_err), 32'd0);
    if (drop_at < 0)
      check("R10", "next frame follows at once", 32'(frame_start), 32'd1);
    else
      check("R9", "no frame after disable", 32'(frame_start), 32'd0);
  endtask

  task automatic idle_quiet(input int n);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      if (frame_sync !== 1'b0 || ser_data !== 1'b0 || frame_start !== 1'b0) bad++;
      @(negedge clk);
    end
    check("R9", "outputs quiet while halted", 32'(bad), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [NS-1:0] f;
    rst_n = 1'b0;
    en = 1'b0;
    in_valid = 1'b0;
    in_slot_valid = '0;
    in_slot_data = '0;
    in_codec_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "sync after reset", 32'(frame_sync), 32'd0);
    check("R11", "data after reset", 32'(ser_data), 32'd0);
    check("R11", "start after reset", 32'(frame_start), 32'd0);
    check("R11", "ready after reset", 32'(in_ready), 32'd1);
    idle_quiet(20);

    // First enabled frame has no descriptor: all zeros.
    en = 1'b1;
    @(negedge clk);
    check("R9", "frame opens after enable", 32'(frame_start), 32'd1);
    capture('0, -1);

    // Sweep of flag patterns and codec IDs.
    for (int v = 0; v < 40; v++) begin
      if (v == 0) f = '0;
      else if (v == 1) f = '1;
      else if (v < 14) f = NS'(1) << (v - 2);
      else if (v < 26) f = ~(NS'(1) << (v - 14));
      else f = NS'((v * 1103515245 + 12345) >>> 16);
      push(f, mk_data(v), 2'(v % 4));
      wait_next_start();
      capture(exp_frame(f, mk_data(v), 2'(v % 4)), -1);
      if (v % 8 == 0) capture('0, -1);   // R8: nothing stored for this one
    end

    // Back-pressure: second descriptor waits for the first to be consumed.
    push(12'hA5C, mk_data(100), 2'd1);
    push(12'h3F0, mk_data(101), 2'd2);
    wait_next_start();
    capture(exp_frame(12'h3F0, mk_data(101), 2'd2), -1);

    // Disable mid-frame, store during pause, resume.
    push(12'hFFF, mk_data(200), 2'd3);
    wait_next_start();
    capture(exp_frame(12'hFFF, mk_data(200), 2'd3), 100);
    idle_quiet(300);
    push(12'h813, mk_data(201), 2'd1);
    idle_quiet(50);
    en = 1'b1;
    @(negedge clk);
    check("R9", "frame opens after re-enable", 32'(frame_start), 32'd1);
    capture(exp_frame(12'h813, mk_data(201), 2'd1), -1);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule